// File: doc/BRIEF.md
# DMA Burst Length Planner

The planner splits one DMA transfer, given as a start address and a total beat count, into a series of bus bursts. Each burst command carries an address, a beat count and the length field (beats minus one). Commands go out one at a time under a valid/ready handshake. When the last command has been accepted, the planner raises a one-cycle done pulse.

The burst size comes from two configuration words, both sampled when the transfer starts. The bus-mode word holds the programmable burst length (PBL), a multiplier enable and a fixed-burst flag. The burst-enable mask marks which power-of-two lengths from 4 to 256 beats are allowed. In non-fixed mode the mask only sets an upper limit. In fixed mode every burst is exactly one of the enabled lengths. Any remainder too short for an enabled length goes out as single beats.

Top module: `dma_burst_planner`

## Requirements
- R1: After reset, busy_o, cmd_valid_o, done_o and cfg_err_o are all low.
- R2: The PBL is bus_mode_i[21:17]. When bus_mode_i[24] is clear, the effective PBL equals the PBL. When bus_mode_i[24] is set, the effective PBL is PBL×4, or PBL×8 when MULT_X8=1.
- R3: When bus_mode_i[16] is clear (non-fixed mode), each burst has min(effective PBL, largest enabled length, remaining beats) beats. Mask bit k (1..7) enables a length of 2^(k+1) beats.
- R4: When bus_mode_i[16] is set (fixed mode), each burst has the largest enabled length that does not exceed min(effective PBL, remaining beats). When no enabled length fits the remaining beats, the burst has 1 beat.
- R5: burst_en_i[0] has no effect. A mask of 8'hFF behaves like 8'hFE.
- R6: A configuration error occurs when mask bits 7:1 are all zero, when the effective PBL is zero, or when fixed mode is set and every enabled length exceeds the effective PBL. On such an error, cfg_err_o is high from the cycle after start until the next start, and every burst has 1 beat.
- R7: cmd_len_o equals cmd_beats_o − 1 whenever cmd_valid_o is high.
- R8: The first command's address is start_addr_i. After each accepted command, the address advances by beats × BEAT_BYTES.
- R9: While cmd_valid_o is high and cmd_ready_i is low, the command stays unchanged in the next cycle.
- R10: done_o is high for exactly one cycle, in the cycle after the last handshake. A start with zero beats gives a done pulse in the next cycle and issues no command.
- R11: start_i is ignored while busy_o is high.
- R12: Configuration inputs are sampled only at an accepted start. Changing them during a transfer has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted while idle |
| start_addr_i | input | ADDR_W | Transfer start address |
| total_beats_i | input | CNT_W | Total beats in the transfer |
| bus_mode_i | input | 32 | Bus-mode word: PBL, multiplier enable, fixed-burst flag |
| burst_en_i | input | 8 | Allowed-length mask, bits 7:1 |
| cmd_ready_i | input | 1 | Consumer accepts the current command |
| busy_o | output | 1 | Transfer in progress |
| cmd_valid_o | output | 1 | Command valid |
| cmd_addr_o | output | ADDR_W | Burst start address |
| cmd_beats_o | output | 9 | Burst beat count |
| cmd_len_o | output | 8 | Burst length field, beats − 1 |
| done_o | output | 1 | One-cycle pulse when the transfer has been issued |
| cfg_err_o | output | 1 | Latched configuration is unusable |

## Verification
An error in the remaining-count register shows up at the ports in two ways. The size of the final bursts is wrong, and done_o arrives one or more handshakes early or late. An error in the latched configuration shows up on the very first command, as a wrong beat count or as a fixed-mode length that is not enabled. An error in the address register is visible on the command after the next handshake. The bench checks every command against its own model. Random back-pressure exercises the hold behaviour, and a second start plus changed configuration words are injected in the middle of transfers.

// File: rtl/dma_bp_pkg.sv
package dma_bp_pkg;
  localparam int BEAT_W    = 9;
  localparam int MASK_W    = 8;
  localparam int PBL_LSB   = 17;
  localparam int PBL_W     = 5;
  localparam int FIXED_BIT = 16;
  localparam int MULT_BIT  = 24;

  typedef struct packed {
    logic              fixed;
    logic              err;
    logic [BEAT_W-1:0] limit;
    logic [MASK_W-1:0] mask;
  } cfg_t;

  function automatic logic [BEAT_W-1:0] len_of(input int k);
    return BEAT_W'(1) << (k + 1);
  endfunction
endpackage

// File: rtl/dma_bp_cfg_decode.sv
module dma_bp_cfg_decode
  import dma_bp_pkg::*;
#(
  parameter bit MULT_X8 = 1'b0
) (
  input  logic [PBL_W-1:0]  pbl_i,
  input  logic              mult_en_i,
  input  logic              fixed_i,
  input  logic [MASK_W-1:0] burst_en_i,
  output cfg_t              cfg_o
);
  localparam int MSH = MULT_X8 ? 3 : 2;

  logic [BEAT_W-1:0] eff, max_len, min_len;
  logic [MASK_W-1:0] mask;

  always_comb begin
    eff     = mult_en_i ? (BEAT_W'(pbl_i) << MSH) : BEAT_W'(pbl_i);
    mask    = burst_en_i & ~MASK_W'(1);
    max_len = '0;
    min_len = '0;
    for (int k = 1; k < MASK_W; k++)
      if (mask[k]) max_len = len_of(k);
    for (int k = MASK_W - 1; k >= 1; k--)
      if (mask[k]) min_len = len_of(k);
    cfg_o.mask  = mask;
    cfg_o.fixed = fixed_i;
    cfg_o.limit = (eff < max_len) ? eff : max_len;
    cfg_o.err   = (mask == '0) || (eff == '0) || (fixed_i && (min_len > eff));
  end
endmodule

// File: rtl/dma_bp_size.sv
module dma_bp_size
  import dma_bp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  cfg_t              cfg_i,
  input  logic [CNT_W-1:0]  rem_i,
  output logic [BEAT_W-1:0] beats_o
);
  logic [BEAT_W-1:0] cap, pick;
  logic [MASK_W-1:0] fit;

  assign cap = (rem_i < CNT_W'(cfg_i.limit)) ? rem_i[BEAT_W-1:0] : cfg_i.limit;

  assign fit[0] = 1'b0;
  for (genvar k = 1; k < MASK_W; k++) begin : g_fit
    assign fit[k] = cfg_i.mask[k] && (len_of(k) <= cap);
  end

  always_comb begin
    pick = BEAT_W'(1);
    for (int k = 1; k < MASK_W; k++)
      if (fit[k]) pick = len_of(k);
    if (cfg_i.err)        beats_o = BEAT_W'(1);
    else if (cfg_i.fixed) beats_o = pick;
    else                  beats_o = cap;
  end
endmodule

// File: rtl/dma_burst_planner.sv
module dma_burst_planner
  import dma_bp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int BEAT_BYTES = 8,
  parameter bit MULT_X8    = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  total_beats_i,
  input  logic [31:0]       bus_mode_i,
  input  logic [7:0]        burst_en_i,
  input  logic              cmd_ready_i,
  output logic              busy_o,
  output logic              cmd_valid_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [8:0]        cmd_beats_o,
  output logic [7:0]        cmd_len_o,
  output logic              done_o,
  output logic              cfg_err_o
);
  localparam int BEAT_SHIFT = $clog2(BEAT_BYTES);

  cfg_t              cfg_d, cfg_q;
  logic              busy_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q;
  logic [BEAT_W-1:0] beats;
  logic              accept, fire;

  dma_bp_cfg_decode #(.MULT_X8(MULT_X8)) u_decode (
    .pbl_i     (bus_mode_i[PBL_LSB +: PBL_W]),
    .mult_en_i (bus_mode_i[MULT_BIT]),
    .fixed_i   (bus_mode_i[FIXED_BIT]),
    .burst_en_i(burst_en_i),
    .cfg_o     (cfg_d)
  );

  dma_bp_size #(.CNT_W(CNT_W)) u_size (
    .cfg_i  (cfg_q),
    .rem_i  (rem_q),
    .beats_o(beats)
  );

  assign accept = start_i && !busy_q;
  assign fire   = busy_q && cmd_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
    end else if (accept) begin
      cfg_q  <= cfg_d;
      addr_q <= start_addr_i;
      rem_q  <= total_beats_i;
      busy_q <= (total_beats_i != '0);
      done_q <= (total_beats_i == '0);
    end else begin
      done_q <= 1'b0;
      if (fire) begin
        addr_q <= addr_q + (ADDR_W'(beats) << BEAT_SHIFT);
        rem_q  <= rem_q - CNT_W'(beats);
        if (rem_q == CNT_W'(beats)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign cmd_valid_o = busy_q;
  assign cmd_addr_o  = addr_q;
  assign cmd_beats_o = beats;
  assign cmd_len_o   = 8'(beats - BEAT_W'(1));
  assign done_o      = done_q;
  assign cfg_err_o   = cfg_q.err;
endmodule

// File: rtl/dma_bp_checker.sv
module dma_bp_checker
  import dma_bp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BEAT_SHIFT = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              ready_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [8:0]        beats_i,
  input logic [7:0]        len_i,
  input logic              done_i,
  input cfg_t              cfg_i
);
  p_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ({1'b0, len_i} + 9'd1) == beats_i);

  p_fixed_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cfg_i.fixed && !cfg_i.err && beats_i != 9'd1)
      |-> ($onehot(beats_i) && (|(cfg_i.mask & beats_i[8:1]))));

  p_cap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !cfg_i.err) |-> (beats_i != 9'd0 && beats_i <= cfg_i.limit));

  p_err_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cfg_i.err) |-> beats_i == 9'd1);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ready_i) |=> (valid_i && $stable(addr_i) && $stable(beats_i)));

  p_addr_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_i) |=>
      (!valid_i || addr_i == $past(addr_i) + (ADDR_W'($past(beats_i)) << BEAT_SHIFT)));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !valid_i);
endmodule

bind dma_burst_planner dma_bp_checker #(.ADDR_W(ADDR_W), .BEAT_SHIFT(BEAT_SHIFT)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(cmd_valid_o),
  .ready_i(cmd_ready_i),
  .addr_i (cmd_addr_o),
  .beats_i(cmd_beats_o),
  .len_i  (cmd_len_o),
  .done_i (done_o),
  .cfg_i  (cfg_q)
);

// File: tb/dma_burst_planner_tb_top.sv
`timescale 1ns/1ps
module dma_burst_planner_tb_top;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;
  localparam int BB     = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] start_addr_i = '0;
  logic [CNT_W-1:0]  total_beats_i = '0;
  logic [31:0]       bus_mode_i = '0;
  logic [7:0]        burst_en_i = '0;
  logic              cmd_ready_i = 1'b0;
  logic              busy_o, cmd_valid_o, done_o, cfg_err_o;
  logic [ADDR_W-1:0] cmd_addr_o;
  logic [8:0]        cmd_beats_o;
  logic [7:0]        cmd_len_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  dma_burst_planner #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BEAT_BYTES(BB), .MULT_X8(1'b0)) dut_i (
    .clk_i, .rst_ni, .start_i, .start_addr_i, .total_beats_i, .bus_mode_i, .burst_en_i,
    .cmd_ready_i, .busy_o, .cmd_valid_o, .cmd_addr_o, .cmd_beats_o, .cmd_len_o, .done_o,
    .cfg_err_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int m_eff(logic [31:0] bm);
    int p = int'(bm[21:17]);
    return bm[24] ? p * 4 : p;
  endfunction

  function automatic bit m_err(logic [31:0] bm, logic [7:0] en);
    int eff = m_eff(bm);
    bit any = 0, fit = 0;
    for (int b = 1; b < 8; b++) begin
      if (en[b]) begin
        any = 1;
        if ((1 << (b + 1)) <= eff) fit = 1;
      end
    end
    if (!any || eff == 0) return 1;
    return bm[16] && !fit;
  endfunction

  function automatic int m_beats(int rem, logic [31:0] bm, logic [7:0] en);
    int eff = m_eff(bm);
    int top = 0;
    int cap;
    if (m_err(bm, en)) return 1;
    for (int b = 7; b >= 1; b--)
      if (en[b] && top == 0) top = 1 << (b + 1);
    cap = eff;
    if (top < cap) cap = top;
    if (rem < cap) cap = rem;
    if (!bm[16]) return cap;
    for (int b = 7; b >= 1; b--)
      if (en[b] && (1 << (b + 1)) <= cap) return 1 << (b + 1);
    return 1;
  endfunction

  function automatic logic [31:0] mk_bm(int pbl, bit mult, bit fixed);
    logic [31:0] v = '0;
    v[21:17] = 5'(pbl);
    v[24] = mult;
    v[16] = fixed;
    return v;
  endfunction

  task automatic run(input logic [31:0] addr, input int total, input logic [31:0] bm,
                     input logic [7:0] en, input bit disturb, input int rdy_pct);
    int rem = total;
    logic [31:0] a = addr;
    int it = 0;
    bit prev_stall = 0;
    string rq = bm[16] ? "R4" : "R3";
    @(negedge clk_i);
    start_i = 1'b1; start_addr_i = addr; total_beats_i = CNT_W'(total);
    bus_mode_i = bm; burst_en_i = en; cmd_ready_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(cfg_err_o == m_err(bm, en), "R6", "cfg_err", cfg_err_o, m_err(bm, en));
    if (total == 0) begin
      chk(done_o && !cmd_valid_o, "R10", "zero-beat done", done_o, 1);
      @(negedge clk_i);
      chk(!done_o && !busy_o, "R10", "zero-beat done width", done_o, 0);
      return;
    end
    while (rem > 0 && it < 5000) begin
      int eb = m_beats(rem, bm, en);
      bit r;
      start_i = 1'b0;
      chk(cmd_valid_o == 1'b1, "R8", "valid while pending", cmd_valid_o, 1);
      chk(cmd_addr_o == a, prev_stall ? "R9" : "R8", "address", cmd_addr_o, a);
      chk(int'(cmd_beats_o) == eb, prev_stall ? "R9" : rq, "beats", cmd_beats_o, eb);
      chk(int'(cmd_len_o) == eb - 1, "R7", "length field", cmd_len_o, eb - 1);
      r = ($urandom % 100) < rdy_pct;
      cmd_ready_i = r;
      if (disturb && it == 2 && rem > eb) begin
        start_i = 1'b1;  // R11: ignored while busy
        start_addr_i = $urandom;
        total_beats_i = CNT_W'($urandom % 50);
        bus_mode_i = $urandom;  // R12: no effect mid-transfer
        burst_en_i = 8'($urandom);
      end
      if (r) begin
        rem -= eb;
        a += 32'(eb * BB);
      end
      prev_stall = !r;
      it++;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    cmd_ready_i = 1'b0;
    chk(done_o && !cmd_valid_o, "R10", "done after last", done_o, 1);
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R10", "done one cycle", done_o, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #12;
    chk(!busy_o && !cmd_valid_o && !done_o && !cfg_err_o, "R1", "reset outputs",
        {busy_o, cmd_valid_o, done_o, cfg_err_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R3: x4 on, eff 32 -> 32,32,32,4
    run(32'h1000, 100, mk_bm(8, 1, 0), 8'hFF, 0, 100);
    // R2: multiplier off, PBL 31, max 32 -> 31 beats
    run(32'h2000, 70, mk_bm(31, 0, 0), 8'h10, 1, 60);
    // R4: eff 16 -> 16,16,8,4,1
    run(32'h3000, 45, mk_bm(4, 1, 1), 8'hFF, 0, 100);
    // R4: only 16 and 4 enabled, eff 31 -> 16,16,4,4
    run(32'h4000, 40, mk_bm(31, 0, 1), 8'h0A, 1, 70);
    // R6: empty mask, zero PBL, unreachable fixed length
    run(32'h5000, 5, mk_bm(8, 1, 0), 8'h00, 0, 100);
    run(32'h6000, 4, mk_bm(0, 1, 0), 8'hFF, 0, 100);
    run(32'h7000, 6, mk_bm(31, 1, 1), 8'h80, 0, 80);
    // R5: bit 0 alone is an empty mask; FF equals FE
    run(32'h8000, 3, mk_bm(8, 1, 1), 8'h01, 0, 100);
    run(32'h9000, 90, mk_bm(16, 1, 1), 8'hFE, 0, 100);
    run(32'h9800, 90, mk_bm(16, 1, 1), 8'hFF, 0, 100);
    // R10: zero-length transfer
    run(32'hA000, 0, mk_bm(8, 1, 0), 8'hFF, 0, 100);
    for (int i = 0; i < 40; i++) begin
      logic [31:0] bm = mk_bm(int'($urandom % 32), 1'($urandom), 1'($urandom));
      logic [7:0] en = 8'($urandom);
      run($urandom & 32'hFFFF_FFF8, int'($urandom % 300) + 1, bm, en, 1'($urandom), 75);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule